// File: doc/BRIEF.md
# Bus Clock Ratio Divider

This block runs on the fast core clock and produces two single-cycle enable pulses. `hclk_en` paces the high-speed bus and `pclk_en` paces the peripheral bus. A three-bit configuration word selects one of five legal ratio sets, given as core : high-speed bus : peripheral bus. The clock gating cells that use these enables sit outside the block.

A new ratio is not applied at the moment it is written. The block first waits a latency counted in high-speed bus periods of the ratio then in force. It then waits for the next point where the whole divider wraps, and only there does it switch. This keeps the pulse trains free of short periods, and every peripheral pulse stays on a high-speed bus pulse.

A `lock_pending` input stands in for a PLL that is relocking. While it is high, any pending change is held back, and the change completes once the input drops. A write with an illegal code changes nothing and raises `wr_err` for one cycle.

Top module: `busclk_ratio_div`

## Requirements
- R1: After reset, `cfg_rd` and `ratio_code` read 3'b000, and `hclk_en` and `pclk_en` are both high in every cycle.
- R2: The code decides the pulse periods in core cycles, written as (high-speed, peripheral): 3'b000 gives (1,1), 3'b001 gives (1,2), 3'b010 gives (2,2), 3'b011 gives (2,4) and 3'b100 gives (4,4). Bit 2 selects quarter-rate for both buses, bit 1 selects half-rate for the high-speed bus, and bit 0 halves the peripheral bus relative to the high-speed bus.
- R3: Every cycle with `pclk_en` high also has `hclk_en` high.
- R4: A write of 3'b101, 3'b110 or 3'b111 leaves `cfg_rd` and `ratio_code` unchanged. `wr_err` is high in the cycle after that write and low in the cycle after that.
- R5: `cfg_rd` shows the last legal code written, starting in the cycle after the write.
- R6: Take a write in cycle w. The latency L is one core cycle when the active code is 3'b000. Otherwise L is ceil(1.5 × the active high-speed period). The new pulse pattern starts, with both enables high, at the first old peripheral pulse slot at or after cycle w+L+1, and `ratio_code` shows the new code from that cycle.
- R7: The switch happens only at a divider wrap point. Until then the old pattern continues unshortened.
- R8: While `lock_pending` is high, `ratio_code` does not change and the latency count is frozen. Once it falls in cycle d, the change completes as if it had been written in cycle d-1.
- R9: A second legal write before a pending change completes replaces that change and restarts the latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 3 | Ratio code to write |
| lock_pending | input | 1 | High while a PLL relock holds changes back |
| cfg_rd | output | 3 | Readback of the configuration register |
| ratio_code | output | 3 | Code currently driving the dividers |
| hclk_en | output | 1 | High-speed bus enable pulse |
| pclk_en | output | 1 | Peripheral bus enable pulse |
| wr_err | output | 1 | One-cycle flag for an illegal write |

## Verification
The bench builds the block with the default `MAX_DIV` of 4. This makes the divider counter exactly wide enough for the quarter-rate codes, so every legal code and every transition between them, including the six-cycle latency out of 1:4:4, is reachable. Each legal switch is measured from the write cycle. The bench predicts the commit slot from the old peripheral pulse grid, checks that no runt pulse appears before that slot, and checks the new periods over two peripheral periods after it.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

  localparam int CODE_W = 3;
  localparam int LAT_W  = 3;

  typedef logic [CODE_W-1:0] code_t;

  function automatic logic code_legal(code_t c);
    return (c <= code_t'(3'd4));
  endfunction

  // high-speed bus divisor in core cycles
  function automatic logic [2:0] hdiv_of(code_t c);
    logic [2:0] d;
    case (c)
      3'd2, 3'd3: d = 3'd2;
      3'd4:       d = 3'd4;
      default:    d = 3'd1;
    endcase
    return d;
  endfunction

  // peripheral bus divisor in core cycles
  function automatic logic [2:0] pdiv_of(code_t c);
    logic [2:0] d;
    case (c)
      3'd1, 3'd2: d = 3'd2;
      3'd3, 3'd4: d = 3'd4;
      default:    d = 3'd1;
    endcase
    return d;
  endfunction

  // core cycles to wait before a change may commit, from the active code
  function automatic logic [LAT_W-1:0] switch_latency(code_t active);
    int h;
    h = int'(hdiv_of(active));
    if (active == code_t'(3'd0)) return LAT_W'(h);
    return LAT_W'((3 * h + 1) / 2);
  endfunction

endpackage

// File: rtl/busclk_cfg_reg.sv
module busclk_cfg_reg
  import busclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  code_t wr_data,
  output code_t cfg_q,
  output logic  accept,
  output logic  wr_err
);

  code_t cfg_d;
  logic  err_d;
  logic  legal;

  always_comb begin
    legal  = code_legal(wr_data);
    accept = wr_en & legal;
    err_d  = wr_en & ~legal;
    cfg_d  = cfg_q;
    if (accept) cfg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      wr_err <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      wr_err <= err_d;
    end
  end

  assert_illegal_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !code_legal(wr_data)) |=> $stable(cfg_q));

  assert_err_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en && !code_legal(wr_data)));

  assert_cfg_always_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal(cfg_q));

endmodule

// File: rtl/busclk_commit_ctl.sv
module busclk_commit_ctl
  import busclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  code_t cfg_q,
  input  logic  lock_pending,
  input  logic  at_wrap,
  output code_t active_q,
  output logic  commit
);

  logic             pend_q, pend_d;
  logic [LAT_W-1:0] cd_q, cd_d;
  logic [LAT_W-1:0] lat;
  code_t            active_d;

  always_comb begin
    lat      = switch_latency(active_q);
    pend_d   = pend_q;
    cd_d     = cd_q;
    active_d = active_q;
    commit   = 1'b0;
    if (accept) begin
      pend_d = 1'b1;
      cd_d   = lat - LAT_W'(1);
    end else if (pend_q && !lock_pending) begin
      if (cd_q != '0) begin
        cd_d = cd_q - LAT_W'(1);
      end else if (at_wrap) begin
        commit   = 1'b1;
        pend_d   = 1'b0;
        active_d = cfg_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      cd_q     <= '0;
      active_q <= '0;
    end else begin
      pend_q   <= pend_d;
      cd_q     <= cd_d;
      active_q <= active_d;
    end
  end

  assert_commit_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> at_wrap);

  assert_no_switch_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_q) |-> !$past(lock_pending));

  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && lock_pending && !accept) |=> $stable(cd_q));

endmodule

// File: rtl/busclk_ratio_cnt.sv
module busclk_ratio_cnt
  import busclk_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t active_q,
  output logic  at_wrap,
  output logic  hclk_en,
  output logic  pclk_en
);

  localparam int NUM_EN = 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       div_sel [NUM_EN];
  logic [NUM_EN-1:0] en;

  always_comb begin
    div_sel[0] = hdiv_of(active_q);
    div_sel[1] = pdiv_of(active_q);
    at_wrap    = (cnt_q == CNT_W'(div_sel[1] - 3'd1));
    cnt_d      = at_wrap ? '0 : cnt_q + CNT_W'(1);
  end

  // divisors are powers of two: an enable fires when the low bits are zero
  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    assign en[g] = ((cnt_q & CNT_W'(div_sel[g] - 3'd1)) == '0);
  end

  assign hclk_en = en[0];
  assign pclk_en = en[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_pclk_on_hclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |-> hclk_en);

  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < int'(pdiv_of(active_q)));

endmodule

// File: rtl/busclk_ratio_div.sv
module busclk_ratio_div
  import busclk_pkg::*;
#(
  parameter int MAX_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  input  logic       lock_pending,
  output logic [2:0] cfg_rd,
  output logic [2:0] ratio_code,
  output logic       hclk_en,
  output logic       pclk_en,
  output logic       wr_err
);

  localparam int CNT_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  code_t cfg_q;
  code_t active_q;
  logic  accept;
  logic  at_wrap;
  logic  commit;

  busclk_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .accept  (accept),
    .wr_err  (wr_err)
  );

  busclk_commit_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .cfg_q        (cfg_q),
    .lock_pending (lock_pending),
    .at_wrap      (at_wrap),
    .active_q     (active_q),
    .commit       (commit)
  );

  busclk_ratio_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_q (active_q),
    .at_wrap  (at_wrap),
    .hclk_en  (hclk_en),
    .pclk_en  (pclk_en)
  );

  assign cfg_rd     = cfg_q;
  assign ratio_code = active_q;

  assert_switch_on_pclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (pclk_en && hclk_en));

endmodule

// File: tb/busclk_ratio_div_test.sv
module busclk_ratio_div_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = 3'd0;
  logic       lock_pending = 1'b0;
  logic [2:0] cfg_rd;
  logic [2:0] ratio_code;
  logic       hclk_en;
  logic       pclk_en;
  logic       wr_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_p = 0;
  int cur = 0;
  bit done = 1'b0;
  bit [255:0] hk_hist;
  bit [255:0] pk_hist;

  busclk_ratio_div uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lock_pending(lock_pending), .cfg_rd(cfg_rd), .ratio_code(ratio_code),
    .hclk_en(hclk_en), .pclk_en(pclk_en), .wr_err(wr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    hk_hist[cyc[7:0]] = hclk_en;
    pk_hist[cyc[7:0]] = pclk_en;
    if (pclk_en) last_p = cyc;
  end

  function automatic int exp_h(int c);
    if (c == 2 || c == 3) return 2;
    if (c == 4) return 4;
    return 1;
  endfunction

  function automatic int exp_p(int c);
    if (c == 1 || c == 2) return 2;
    if (c == 3 || c == 4) return 4;
    return 1;
  endfunction

  function automatic int exp_lat(int active);
    if (active == 0) return 1;
    return (3 * exp_h(active) + 1) / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // write one code; returns the write cycle and leaves the bench in cycle w+1
  task automatic do_write(input int c, output int w);
    step();
    w = cyc;
    wr_en = 1'b1;
    wr_data = 3'(c);
    step();
    wr_en = 1'b0;
  endtask

  task automatic verify_switch(input int w, input int p0, input int pold,
                               input int lat, input int c);
    int s, hp, pp, bad_old, bad_h, bad_p, bad_al;
    s = p0;
    while (s < w + lat + 1) s += pold;
    hp = exp_h(c);
    pp = exp_p(c);
    while (cyc < s + 2 * pp + 1) step();
    bad_old = 0; bad_h = 0; bad_p = 0; bad_al = 0;
    for (int t = w + 1; t < s; t++)
      if (pk_hist[t[7:0]] != (((t - p0) % pold) == 0)) bad_old++;
    chk(bad_old == 0, "R7 old pattern kept until wrap", bad_old, 0);
    chk(pk_hist[s[7:0]] && hk_hist[s[7:0]], "R6 new pattern starts at predicted slot",
        int'(pk_hist[s[7:0]]), 1);
    for (int t = s; t < s + 2 * pp; t++) begin
      if (hk_hist[t[7:0]] != (((t - s) % hp) == 0)) bad_h++;
      if (pk_hist[t[7:0]] != (((t - s) % pp) == 0)) bad_p++;
      if (pk_hist[t[7:0]] && !hk_hist[t[7:0]]) bad_al++;
    end
    chk(bad_h == 0, "R2 high-speed period", bad_h, 0);
    chk(bad_p == 0, "R2 peripheral period", bad_p, 0);
    chk(bad_al == 0, "R3 peripheral pulse on high-speed pulse", bad_al, 0);
    chk(ratio_code == 3'(c), "R6 active code", int'(ratio_code), c);
    chk(cfg_rd == 3'(c), "R5 readback", int'(cfg_rd), c);
  endtask

  task automatic do_switch(input int c, input int pre);
    int w, p0, pold, lat, wdummy;
    if (pre >= 0) do_write(pre, wdummy);
    step();
    w = cyc;
    p0 = last_p;
    pold = exp_p(cur);
    lat = exp_lat(cur);
    wr_en = 1'b1;
    wr_data = 3'(c);
    step();
    wr_en = 1'b0;
    verify_switch(w, p0, pold, lat, c);
    cur = c;
  endtask

  task automatic do_illegal(input int c);
    int w;
    logic [2:0] old_cfg;
    old_cfg = cfg_rd;
    do_write(c, w);
    chk(wr_err == 1'b1, "R4 error flag raised", int'(wr_err), 1);
    step();
    chk(wr_err == 1'b0, "R4 error flag one cycle", int'(wr_err), 0);
    chk(cfg_rd == old_cfg, "R4 readback unchanged", int'(cfg_rd), int'(old_cfg));
    repeat (8) step();
    chk(ratio_code == 3'(cur), "R4 ratio unchanged", int'(ratio_code), cur);
  endtask

  task automatic do_lock_switch(input int c);
    int w, d, p0;
    step();
    lock_pending = 1'b1;
    do_write(c, w);
    repeat (20) step();
    chk(ratio_code == 3'(cur), "R8 held while lock pending", int'(ratio_code), cur);
    chk(cfg_rd == 3'(c), "R5 readback while locked", int'(cfg_rd), c);
    step();
    d = cyc;
    p0 = last_p;
    lock_pending = 1'b0;
    verify_switch(d - 1, p0, exp_p(cur), exp_lat(cur), c);
    cur = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(cfg_rd == 3'd0, "R1 readback after reset", int'(cfg_rd), 0);
    chk(ratio_code == 3'd0, "R1 code after reset", int'(ratio_code), 0);
    chk(hclk_en && pclk_en, "R1 enables every cycle", int'(hclk_en & pclk_en), 1);
    step();
    chk(hclk_en && pclk_en, "R1 enables every cycle", int'(hclk_en & pclk_en), 1);

    // directed corners
    do_switch(1, -1);   // leaving default: one-cycle latency
    do_switch(0, -1);
    do_switch(4, -1);   // quarter rate
    do_switch(3, -1);   // out of 1:4:4, six-cycle latency
    do_switch(3, -1);   // rewrite same code
    do_switch(0, -1);
    do_illegal(5);
    do_illegal(7);
    do_switch(4, -1);
    do_switch(3, 1);    // R9: replace a pending change
    do_lock_switch(2);  // R8
    do_switch(0, 4);    // R9 from half rate

    void'($urandom(32'd4242));
    for (int i = 0; i < 40; i++) begin
      int c;
      c = int'($urandom % 8);
      repeat (int'($urandom % 4)) step();
      if (c > 4) do_illegal(c);
      else if (($urandom % 6) == 0) do_lock_switch(c);
      else do_switch(c, -1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule